// File: doc/BRIEF.md
# Programmable Sample Strobe Generator

This block creates the per-pixel sample strobe inside a video front end. Every register runs on the master clock. There are two ways to obtain the strobe. In pass-through mode, an external sync line already carries a pulse one master-clock period wide at the pixel rate, and the block resynchronises that pulse and forwards it. In detect mode, the sync line may carry any waveform at the pixel rate, for example a sensor shift clock. The block then watches for one chosen edge of that waveform, either rising or falling. Each time it sees that edge it emits its own strobe of one master-clock cycle. That strobe can be postponed by zero to seven master-clock periods.

Whichever strobe source is selected, the block also raises a sample-enable. The sample-enable marks the first rising master-clock edge after the strobe has ended, which is where downstream logic captures the pixel. The sync line is asynchronous, so it first passes through a two-flop synchroniser. The master clock must run at least twice as fast as the sync line, for example 30 MHz against 15 MHz.

Top module: `sample_strobe_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first cycles after it is released, `strobe_o` and `sample_en_o` are 0.
- R2: With `det_en_i` = 0, `strobe_o` copies the sync line with three rising edges of latency. A level first sampled high at edge n appears on `strobe_o` after edge n+2 and stays for as many cycles as the line was high.
- R3: With `det_en_i` = 1 and `edge_rise_i` = 1, only low-to-high transitions of the synchronised line produce a strobe. High-to-low transitions produce none.
- R4: With `det_en_i` = 1 and `edge_rise_i` = 0, only high-to-low transitions of the synchronised line produce a strobe. Low-to-high transitions produce none.
- R5: A selected transition first sampled at edge n, with `dly_i` = d (0..7) at the edge where it is detected, drives `strobe_o` high after edge n+2+d. With d = 0, this is the same cycle as in R2.
- R6: In detect mode, each detected transition produces a strobe exactly one cycle wide.
- R7: If a new selected transition is detected while a delayed strobe is still pending, the pending strobe is discarded and the delay restarts from the new transition using the current `dly_i`. This also applies when the restart falls in the cycle in which the pending strobe would have fired.
- R8: `sample_en_o` is high for exactly one cycle: the cycle right after the last high cycle of `strobe_o`. It is high at no other time, in both modes.
- R9: Clearing `det_en_i` discards any pending delayed strobe. No strobe appears later because of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_pin_i | input | 1 | Asynchronous sync line (pixel-rate pulse or clock) |
| det_en_i | input | 1 | 1 = edge-detect mode, 0 = pass-through mode |
| edge_rise_i | input | 1 | Detect polarity: 1 = rising, 0 = falling |
| dly_i | input | 3 | Strobe delay in master-clock periods, 0..7 |
| strobe_o | output | 1 | Internal sample strobe |
| sample_en_o | output | 1 | Marks the first rising edge after the strobe |

## Verification
Two things can land in the same cycle: a fresh edge detection, and the expiry of the delay counter of an earlier edge. The bench forces this directly. It sets the delay to 4 and toggles the sync line with a period of exactly 4 cycles, so each new rising edge is detected on the cycle the previous pulse would have fired. It then repeats the run with a period shorter than the delay. In both runs the bench reference tracks an absolute due cycle for the pending pulse and lets a new edge replace it, so no strobe may appear until the line stops toggling, and then exactly one appears a full delay after the last edge. Random runs with changing polarity, delay and mode add many more such coincidences.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  // True when the current/previous pair forms the selected transition.
  function automatic logic edge_match(input logic rise, input logic cur, input logic prev);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  // True in the last high cycle of a level whose next value is known.
  function automatic logic last_high(input logic now, input logic nxt);
    return now & ~nxt;
  endfunction

endpackage

// File: rtl/ssg_sync.sv
module ssg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ssg_edge_pick.sv
module ssg_edge_pick
  import ssg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_en_i,
  input  logic rise_i,
  input  logic level_i,
  output logic hit_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign hit_o = det_en_i & edge_match(rise_i, level_i, prev_q);

  // Same-polarity transitions cannot occur on two consecutive cycles.
  assert_sel_edge_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (!hit_o || (rise_i != $past(rise_i))));

endmodule

// File: rtl/ssg_delay.sv
module ssg_delay #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_en_i,
  input  logic             edge_hit_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);

  localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;

  logic             pending_q;
  logic [DLY_W-1:0] cnt_q;
  logic             expire;

  assign expire = pending_q && (cnt_q == CNT_ONE);

  // A fresh edge takes precedence over an expiring earlier one.
  always_comb begin
    if (!det_en_i)       fire_o = 1'b0;
    else if (edge_hit_i) fire_o = (dly_i == CNT_ZERO);
    else                 fire_o = expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!det_en_i) begin
      pending_q <= 1'b0;
    end else if (edge_hit_i) begin
      pending_q <= (dly_i != CNT_ZERO);
      cnt_q     <= dly_i;
    end else if (expire) begin
      pending_q <= 1'b0;
    end else if (pending_q) begin
      cnt_q     <= cnt_q - CNT_ONE;
    end
  end

  assert_restart_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && edge_hit_i && (dly_i != CNT_ZERO)) |=> (pending_q && (cnt_q == $past(dly_i))));

  assert_countdown_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && pending_q && !edge_hit_i && (cnt_q != CNT_ONE))
      |=> (pending_q && (cnt_q == $past(cnt_q) - CNT_ONE)));

  assert_disable_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !pending_q);

endmodule

// File: rtl/ssg_out.sv
module ssg_out
  import ssg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_en_i,
  input  logic fire_i,
  input  logic pin_sync_i,
  output logic strobe_o,
  output logic sample_en_o
);

  logic strobe_d, strobe_q, samp_q;

  assign strobe_d = det_en_i ? fire_i : pin_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      samp_q   <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      samp_q   <= last_high(strobe_q, strobe_d);
    end
  end

  assign strobe_o    = strobe_q;
  assign sample_en_o = samp_q;

  assert_samp_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q) |-> samp_q);

  assert_samp_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_q |-> ($past(strobe_q) && !strobe_q));

endmodule

// File: rtl/sample_strobe_gen.sv
module sample_strobe_gen #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DLY_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_pin_i,
  input  logic             det_en_i,
  input  logic             edge_rise_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             strobe_o,
  output logic             sample_en_o
);

  logic pin_sync;
  logic edge_hit;
  logic fire;

  ssg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_pin_i),
    .sync_o  (pin_sync)
  );

  ssg_edge_pick u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .det_en_i (det_en_i),
    .rise_i   (edge_rise_i),
    .level_i  (pin_sync),
    .hit_o    (edge_hit)
  );

  ssg_delay #(.DLY_W(DLY_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_en_i   (det_en_i),
    .edge_hit_i (edge_hit),
    .dly_i      (dly_i),
    .fire_o     (fire)
  );

  ssg_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .det_en_i    (det_en_i),
    .fire_i      (fire),
    .pin_sync_i  (pin_sync),
    .strobe_o    (strobe_o),
    .sample_en_o (sample_en_o)
  );

  assert_zero_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && edge_hit && (dly_i == '0)) |=> strobe_o);

  assert_detect_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_en_i && edge_hit && (dly_i == '0)) |=> ##1 (!strobe_o || $past(det_en_i) == 1'b0 || det_en_i == 1'b0 || $past(edge_hit)));

endmodule

// File: tb/sample_strobe_gen_tb_top.sv
module sample_strobe_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_pin = 1'b0;
  logic       det_en = 1'b0;
  logic       edge_rise = 1'b1;
  logic [2:0] dly = 3'd0;
  logic       strobe, sample_en;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit r6_mon = 1'b0;
  bit finished = 1'b0;
  string ph = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_strobe_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sync_pin_i  (sync_pin),
    .det_en_i    (det_en),
    .edge_rise_i (edge_rise),
    .dly_i       (dly),
    .strobe_o    (strobe),
    .sample_en_o (sample_en)
  );

  // ---- reference: absolute due cycle for a pending strobe ----
  function automatic bit sel_edge(bit rise, bit now_v, bit old_v);
    if (rise) return now_v && !old_v;
    return old_v && !now_v;
  endfunction

  int m_cyc = 0;
  int m_due = -1;
  bit m_p1 = 0, m_p2 = 0, m_p3 = 0;
  bit e_stb = 0, e_samp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc <= 0; m_due <= -1;
      m_p1 <= 0; m_p2 <= 0; m_p3 <= 0;
      e_stb <= 0; e_samp <= 0;
    end else begin
      bit ev, nxt;
      ev = det_en && sel_edge(edge_rise, m_p2, m_p3);
      if (det_en) nxt = ev ? (dly == 3'd0) : (m_due == m_cyc);
      else        nxt = m_p2;
      if (!det_en)                 m_due <= -1;
      else if (ev)                 m_due <= (dly == 3'd0) ? -1 : m_cyc + int'(dly);
      else if (m_due == m_cyc)     m_due <= -1;
      m_p1 <= sync_pin; m_p2 <= m_p1; m_p3 <= m_p2;
      e_samp <= e_stb && !nxt;
      e_stb <= nxt;
      m_cyc <= m_cyc + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  logic prev_stb = 1'b0;
  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      check(ph, strobe, e_stb);
      check("R8", sample_en, e_samp);
      if (r6_mon && det_en && strobe) begin
        n_chk++;
        if (prev_stb) begin
          n_fail++;
          $display("FAIL R6: actual=strobe high 2 cycles expected=1 cycle at t=%0t", $time);
        end
      end
    end
    prev_stb = strobe;
  end

  task automatic hold(input logic v, input int n);
    sync_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", strobe, 1'b0);
    check("R1", sample_en, 1'b0);
    sync_pin = 1'b1;
    @(negedge clk);
    check("R1", strobe, 1'b0);
    check("R1", sample_en, 1'b0);
    sync_pin = 1'b0;
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (4) @(negedge clk);

    // R2: pass-through of one-cycle and wider pulses
    ph = "R2"; det_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      hold(1'b1, 1); hold(1'b0, 3 + k);
    end
    hold(1'b1, 3); hold(1'b0, 5);

    // R3: rising detect; falling edges must give nothing
    ph = "R3"; det_en = 1'b1; edge_rise = 1'b1; dly = 3'd0; r6_mon = 1'b1;
    for (int k = 0; k < 4; k++) begin hold(1'b1, 2); hold(1'b0, 2); end
    hold(1'b1, 5); hold(1'b0, 6);

    // R4: falling detect
    ph = "R4"; edge_rise = 1'b0;
    for (int k = 0; k < 4; k++) begin hold(1'b1, 2); hold(1'b0, 2); end
    hold(1'b1, 5); hold(1'b0, 6);

    // R5: every delay value
    ph = "R5"; edge_rise = 1'b1;
    for (int d = 0; d < 8; d++) begin
      dly = 3'(d);
      hold(1'b1, 2); hold(1'b0, d + 6);
    end

    // R7: restart lands on the expiry cycle, then restart before expiry
    ph = "R7"; dly = 3'd4;
    for (int k = 0; k < 6; k++) begin hold(1'b1, 2); hold(1'b0, 2); end
    hold(1'b0, 10);
    dly = 3'd6;
    for (int k = 0; k < 5; k++) begin hold(1'b1, 2); hold(1'b0, 2); end
    hold(1'b0, 12);

    // R9: leaving detect mode drops a pending strobe
    ph = "R9"; dly = 3'd6;
    hold(1'b1, 2); hold(1'b0, 1);
    det_en = 1'b0;
    hold(1'b0, 10);
    det_en = 1'b1;
    hold(1'b0, 4);

    // Random mix: mode, polarity, delay; line held at least 2 cycles
    r6_mon = 1'b0;
    for (int c = 0; c < 300; c++) begin
      det_en = ($urandom % 4) != 0;
      edge_rise = $urandom % 2;
      dly = 3'($urandom % 8);
      ph = det_en ? (edge_rise ? "R3" : "R4") : "R2";
      for (int t = 0; t < 6; t++) hold(~sync_pin, 2 + int'($urandom % 9));
    end
    hold(1'b0, 12);
    report();
  end

endmodule